// File: doc/BRIEF.md
# Buck-Boost Rectifier Duty Scheduler

This block works out, once per switching period, the two duty cycles that drive a buck-boost rectifier built around an impedance network. The first is the buck duty, the fraction of the period in which the front-end switch conducts. The second is the shoot-through duty, the fraction in which the inverter bridge is shorted to boost. It takes four inputs:

- the modulation index (rectified grid voltage over intermediate voltage);
- an upper bound on the buck duty, computed upstream to keep the inductor current high enough;
- a signed inductor-voltage correction from the current loop;
- the rectified grid voltage and the capacitor voltage.

It returns the final two duties and an operating-mode code.

The steady-state buck duty is the smallest of three curves. Two are reciprocal curves in the index: one for buck operation and one for boost operation. The third is the externally supplied bound. The winning curve fixes the operating mode. The mode then decides how the steady-state shoot-through duty is formed, and which of the two duties receives the controller correction, divided by a mode-dependent voltage. All arithmetic is unsigned or signed fixed point. A single sequential restoring divider is shared between the reciprocal and the correction division. A valid/ready pair paces requests.

Top module: `pfc_duty_sched`

## Requirements
- R1: `in_ready` is high while the block is idle. A request is taken on a rising edge with `in_valid` and `in_ready` both high. `in_ready` then stays low until the result appears, and `in_valid` has no effect during that time.
- R2: `out_valid` is a single-cycle pulse, seen exactly 2*DIV_W+5 clock edges after the accepting edge (69 with defaults). `duty_a`, `duty_b` and `op_mode` change only together with that pulse, and they reset to zero.
- R3: `m_idx` is unsigned Q2.14 (16384 = 1.0). Values above 32768 are treated as 32768 (2.0). `da_bb` and both duties are unsigned Q1.15 (32768 = 1.0).
- R4: The candidate buck duty is floor(2^29/m) when m >= 16384, with mode code 0 (buck). Otherwise it is floor(2^29/(32768-m)), with mode code 1 (boost).
- R5: When `da_bb` is strictly less than the candidate, the steady-state buck duty is `da_bb` and the mode code is 2 (buck-boost). On a tie the candidate wins. Mode code 3 never appears.
- R6: The steady-state shoot-through duty depends on the mode. In buck mode it is 0. In boost mode it is 32768 minus the buck duty. In buck-boost mode it is floor((32768 - floor(m*DA/16384))/2), or 0 if the product reaches 32768.
- R7: In buck mode the correction vL/|vG| is added to the buck duty and the shoot-through duty gets none.
- R8: In boost mode the correction c = vL/(|vG| - 2*vC) is added to the buck duty and subtracted from the shoot-through duty.
- R9: In buck-boost mode the buck duty gets no correction, and vL/(2*vC) is added to the shoot-through duty.
- R10: A correction has magnitude floor(|vL|*32768/|den|), capped at 32768. Its sign is negative when exactly one of vL and den is negative. A zero denominator gives a zero correction.
- R11: Each corrected duty is saturated to the range 0 to 32768. If their sum then exceeds 32768, `duty_b` becomes 32768 minus `duty_a`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request can be taken |
| m_idx | input | 16 | Modulation index, Q2.14 |
| da_bb | input | 16 | Buck-boost bound on buck duty, Q1.15 |
| vl_corr | input | 16 | Signed inductor-voltage correction |
| vg_abs | input | 16 | Rectified grid voltage, same scale as vl_corr |
| vc_avg | input | 16 | Capacitor voltage, same scale as vl_corr |
| out_valid | output | 1 | One-cycle result strobe |
| duty_a | output | 16 | Final buck duty, Q1.15 |
| duty_b | output | 16 | Final shoot-through duty, Q1.15 |
| op_mode | output | 2 | 0 buck, 1 boost, 2 buck-boost |

## Verification
The result of a request is due exactly 69 edges after the accepting edge: two 32-step divisions plus five control steps. Until then `in_ready` must stay low and the outputs must keep their previous values. The bench model counts edges from acceptance, raises its expected strobe on the 69th edge, and compares ready, strobe, both duties and mode on every falling edge. It therefore catches a result that is early or late by a single cycle as well as a wrong value. Requests are spaced so that the next one is offered only once the model expects the block to be idle again.

// File: rtl/pfc_duty_pkg.sv
package pfc_duty_pkg;

  typedef enum logic [1:0] {
    MODE_BUCK  = 2'd0,
    MODE_BOOST = 2'd1,
    MODE_BB    = 2'd2
  } pfc_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_Q1   = 3'd1,
    ST_W1   = 3'd2,
    ST_CALC = 3'd3,
    ST_Q2   = 3'd4,
    ST_W2   = 3'd5
  } sched_st_e;

endpackage

// File: rtl/pfc_restoring_div.sv
module pfc_restoring_div #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo,
  output logic             done
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q, rem_d, den_q, den_d;
  logic [NUM_W-1:0] quo_q, quo_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [DEN_W:0]   shifted;
  logic [DEN_W-1:0] diff;
  logic             ge;

  assign shifted = {rem_q, quo_q[NUM_W-1]};
  assign ge      = shifted >= {1'b0, den_q};
  assign diff    = shifted[DEN_W-1:0] - den_q;

  always_comb begin
    rem_d  = rem_q;
    den_d  = den_q;
    quo_d  = quo_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start) begin
      rem_d  = '0;
      den_d  = den;
      quo_d  = num;
      cnt_d  = CNT_W'(NUM_W);
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d = ge ? diff : shifted[DEN_W-1:0];
      quo_d = {quo_q[NUM_W-2:0], ge};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (start || busy_q) begin
        rem_q  <= rem_d;
        den_q  <= den_d;
        quo_q  <= quo_d;
        cnt_q  <= cnt_d;
        busy_q <= busy_d;
      end
    end
  end

  assign quo  = quo_q;
  assign done = done_q;
endmodule

// File: rtl/pfc_base_duty.sv
module pfc_base_duty
  import pfc_duty_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEN_W = 19
) (
  input  logic [W-1:0]     m,
  input  logic [W-1:0]     da_bb,
  input  logic [W-1:0]     cand,
  output logic [DEN_W-1:0] cand_den,
  output logic [W-1:0]     da,
  output logic [W-1:0]     db,
  output pfc_mode_e        mode
);
  localparam int          M_FRAC = W - 2;
  localparam logic [W-1:0] ONE_M = W'(1) << M_FRAC;
  localparam logic [W-1:0] TWO_M = W'(1) << (M_FRAC + 1);
  localparam logic [W-1:0] ONE_D = W'(1) << (W - 1);

  logic           m_ge_one;
  logic           bb_wins;
  logic [2*W-1:0] prod;
  logic [2*W-1:0] prod_sh;
  logic [W-1:0]   bb_rem;

  assign m_ge_one = m >= ONE_M;
  assign cand_den = m_ge_one ? DEN_W'(m) : DEN_W'(TWO_M - m);
  assign bb_wins  = da_bb < cand;

  always_comb begin
    if (bb_wins) begin
      da   = da_bb;
      mode = MODE_BB;
    end else begin
      da   = cand;
      mode = m_ge_one ? MODE_BUCK : MODE_BOOST;
    end
  end

  assign prod    = (2*W)'(m) * (2*W)'(da);
  assign prod_sh = prod >> M_FRAC;
  assign bb_rem  = ONE_D - prod_sh[W-1:0];

  always_comb begin
    unique case (mode)
      MODE_BUCK:  db = '0;
      MODE_BOOST: db = ONE_D - da;
      default:    db = (prod_sh >= (2*W)'(ONE_D)) ? '0 : (bb_rem >> 1);
    endcase
  end
endmodule

// File: rtl/pfc_corr_split.sv
module pfc_corr_split
  import pfc_duty_pkg::*;
#(
  parameter int W     = 16,
  parameter int DIV_W = 32,
  parameter int DEN_W = 19
) (
  input  pfc_mode_e          mode,
  input  logic [W-1:0]       da,
  input  logic [W-1:0]       db,
  input  logic signed [W-1:0] vl,
  input  logic [W-1:0]       vg,
  input  logic [W-1:0]       vc,
  input  logic [DIV_W-1:0]   quo,
  output logic [DIV_W-1:0]   num,
  output logic [DEN_W-1:0]   den_mag,
  output logic [W-1:0]       fa,
  output logic [W-1:0]       fb
);
  localparam int                  SW    = DEN_W;
  localparam logic [W-1:0]        ONE_D = W'(1) << (W - 1);
  localparam logic signed [SW-1:0] ONE_S = SW'(ONE_D);

  logic signed [SW-1:0] vg_s, vc2_s, den_s;
  logic                 den_neg;
  logic [W-1:0]         vl_mag;
  logic [W-1:0]         c_mag;
  logic signed [SW-1:0] c_s, ca, cb, sa, sb;
  logic [W-1:0]         fa_c, fb_c;
  logic [W:0]           sum;

  assign vg_s  = signed'(SW'(vg));
  assign vc2_s = signed'(SW'({vc, 1'b0}));

  always_comb begin
    unique case (mode)
      MODE_BUCK:  den_s = vg_s;
      MODE_BOOST: den_s = vg_s - vc2_s;
      default:    den_s = vc2_s;
    endcase
  end

  assign den_neg = den_s[SW-1];
  assign den_mag = den_neg ? DEN_W'(-den_s) : DEN_W'(den_s);
  assign vl_mag  = vl[W-1] ? W'(-vl) : W'(vl);
  assign num     = DIV_W'(vl_mag) << (W - 1);

  assign c_mag = (den_mag == '0) ? '0 :
                 (quo > DIV_W'(ONE_D)) ? ONE_D : quo[W-1:0];
  assign c_s   = (vl[W-1] ^ den_neg) ? -signed'(SW'(c_mag)) : signed'(SW'(c_mag));

  always_comb begin
    unique case (mode)
      MODE_BUCK: begin
        ca = c_s;
        cb = '0;
      end
      MODE_BOOST: begin
        ca = c_s;
        cb = -c_s;
      end
      default: begin
        ca = '0;
        cb = c_s;
      end
    endcase
  end

  assign sa = signed'(SW'(da)) + ca;
  assign sb = signed'(SW'(db)) + cb;

  always_comb begin
    if (sa < 0)          fa_c = '0;
    else if (sa > ONE_S) fa_c = ONE_D;
    else                 fa_c = sa[W-1:0];
    if (sb < 0)          fb_c = '0;
    else if (sb > ONE_S) fb_c = ONE_D;
    else                 fb_c = sb[W-1:0];
  end

  assign sum = {1'b0, fa_c} + {1'b0, fb_c};
  assign fa  = fa_c;
  assign fb  = (sum > {1'b0, ONE_D}) ? (ONE_D - fa_c) : fb_c;
endmodule

// File: rtl/pfc_duty_sched.sv
module pfc_duty_sched
  import pfc_duty_pkg::*;
#(
  parameter int W     = 16,
  parameter int DIV_W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] m_idx,
  input  logic [W-1:0] da_bb,
  input  logic [W-1:0] vl_corr,
  input  logic [W-1:0] vg_abs,
  input  logic [W-1:0] vc_avg,
  output logic         out_valid,
  output logic [W-1:0] duty_a,
  output logic [W-1:0] duty_b,
  output logic [1:0]   op_mode
);
  localparam int               DEN_W    = W + 3;
  localparam logic [W-1:0]     M_MAX    = W'(1) << (W - 1);
  localparam logic [DIV_W-1:0] CAND_NUM = DIV_W'(1) << (2*W - 3);

  sched_st_e state_q, state_d;

  logic [W-1:0] m_q, dabb_q, vl_q, vg_q, vc_q;
  logic [W-1:0] da_q, db_q;
  pfc_mode_e    bmode_q;
  logic [W-1:0] duty_a_q, duty_b_q;
  pfc_mode_e    omode_q;
  logic         ov_q;

  logic             cap_en, base_en, out_en;
  logic             div_start, div_done;
  logic [DIV_W-1:0] div_num, div_quo, corr_num;
  logic [DEN_W-1:0] div_den, cand_den, corr_den;
  logic [W-1:0]     base_da, base_db, fin_a, fin_b;
  pfc_mode_e        base_mode;

  assign cap_en  = (state_q == ST_IDLE) && in_valid;
  assign base_en = (state_q == ST_CALC);
  assign out_en  = (state_q == ST_W2) && div_done;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (in_valid) state_d = ST_Q1;
      ST_Q1:   state_d = ST_W1;
      ST_W1:   if (div_done) state_d = ST_CALC;
      ST_CALC: state_d = ST_Q2;
      ST_Q2:   state_d = ST_W2;
      ST_W2:   if (div_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign div_start = (state_q == ST_Q1) || (state_q == ST_Q2);
  assign div_num   = (state_q == ST_Q1) ? CAND_NUM : corr_num;
  assign div_den   = (state_q == ST_Q1) ? cand_den : corr_den;

  pfc_restoring_div #(
    .NUM_W(DIV_W),
    .DEN_W(DEN_W)
  ) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .start(div_start),
    .num  (div_num),
    .den  (div_den),
    .quo  (div_quo),
    .done (div_done)
  );

  pfc_base_duty #(
    .W    (W),
    .DEN_W(DEN_W)
  ) u_base (
    .m       (m_q),
    .da_bb   (dabb_q),
    .cand    (div_quo[W-1:0]),
    .cand_den(cand_den),
    .da      (base_da),
    .db      (base_db),
    .mode    (base_mode)
  );

  pfc_corr_split #(
    .W    (W),
    .DIV_W(DIV_W),
    .DEN_W(DEN_W)
  ) u_corr (
    .mode   (bmode_q),
    .da     (da_q),
    .db     (db_q),
    .vl     (signed'(vl_q)),
    .vg     (vg_q),
    .vc     (vc_q),
    .quo    (div_quo),
    .num    (corr_num),
    .den_mag(corr_den),
    .fa     (fin_a),
    .fb     (fin_b)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      m_q      <= '0;
      dabb_q   <= '0;
      vl_q     <= '0;
      vg_q     <= '0;
      vc_q     <= '0;
      da_q     <= '0;
      db_q     <= '0;
      bmode_q  <= MODE_BUCK;
      duty_a_q <= '0;
      duty_b_q <= '0;
      omode_q  <= MODE_BUCK;
      ov_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      ov_q    <= out_en;
      if (cap_en) begin
        m_q    <= (m_idx > M_MAX) ? M_MAX : m_idx;
        dabb_q <= da_bb;
        vl_q   <= vl_corr;
        vg_q   <= vg_abs;
        vc_q   <= vc_avg;
      end
      if (base_en) begin
        da_q    <= base_da;
        db_q    <= base_db;
        bmode_q <= base_mode;
      end
      if (out_en) begin
        duty_a_q <= fin_a;
        duty_b_q <= fin_b;
        omode_q  <= bmode_q;
      end
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = ov_q;
  assign duty_a    = duty_a_q;
  assign duty_b    = duty_b_q;
  assign op_mode   = omode_q;
endmodule

// File: rtl/pfc_duty_sched_chk.sv
module pfc_duty_sched_chk #(
  parameter int W   = 16,
  parameter int LAT = 69
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic [W-1:0] duty_a,
  input logic [W-1:0] duty_b,
  input logic [1:0]   op_mode
);
  localparam int         CW    = $clog2(LAT + 2) + 1;
  localparam logic [W:0] ONE_X = (W+1)'(1) << (W - 1);

  logic [CW-1:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt <= '0;
    end else if (in_valid && in_ready) begin
      lat_cnt <= CW'(1);
    end else if ((lat_cnt != '0) && (lat_cnt <= CW'(LAT))) begin
      lat_cnt <= lat_cnt + 1'b1;
    end
  end

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R1
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (lat_cnt == CW'(LAT + 1))); // R2
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R2
  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(duty_a) && $stable(duty_b) && $stable(op_mode))); // R2
  AST_MODE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (op_mode != 2'd3)); // R5
  AST_BUCK_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (op_mode == 2'd0)) |-> (duty_b == '0)); // R6
  AST_DUTY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (({1'b0, duty_a} <= ONE_X) && ({1'b0, duty_b} <= ONE_X))); // R11
  AST_SUM_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (({1'b0, duty_a} + {1'b0, duty_b}) <= ONE_X)); // R11
endmodule

bind pfc_duty_sched pfc_duty_sched_chk #(
  .W  (W),
  .LAT(2*DIV_W + 5)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .duty_a   (duty_a),
  .duty_b   (duty_b),
  .op_mode  (op_mode)
);

// File: tb/pfc_duty_sched_tb_top.sv
module pfc_duty_sched_tb_top;
  localparam int W     = 16;
  localparam int DIV_W = 32;
  localparam int LAT   = 2*DIV_W + 5;
  localparam longint ONE = 32768;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [W-1:0] m_idx, da_bb, vl_corr, vg_abs, vc_avg;
  logic         out_valid;
  logic [W-1:0] duty_a, duty_b;
  logic [1:0]   op_mode;

  always #2 clk = ~clk;

  pfc_duty_sched #(.W(W), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .m_idx(m_idx), .da_bb(da_bb), .vl_corr(vl_corr), .vg_abs(vg_abs),
    .vc_avg(vc_avg), .out_valid(out_valid), .duty_a(duty_a),
    .duty_b(duty_b), .op_mode(op_mode)
  );

  int     n_cmp = 0;
  int     n_bad = 0;
  int     cyc   = 0;
  bit     finished = 0;
  bit     ref_busy;
  bit     ref_ov;
  int     ref_cnt;
  longint ref_a, ref_b, ref_m;
  longint pend_a, pend_b, pend_m;
  string  ref_tag  = "R2 reset";
  string  pend_tag = "";
  string  next_tag = "";

  task automatic chk(input string tag, input string what, input longint got, input longint exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s actual %0d expected %0d (t=%0t)", tag, what, got, exp, $time);
    end
  endtask

  // Behavioural model of R3..R11
  task automatic model(input longint m, input longint dabb, input longint vl,
                       input longint vg, input longint vc,
                       output longint oa, output longint ob, output longint om);
    longint mm, den1, cand, da, db, den, mag, c, ca, cb, a, b, vla, dena;
    mm = (m > ONE) ? ONE : m;
    if (mm >= 16384) begin den1 = mm; om = 0; end
    else begin den1 = 32768 - mm; om = 1; end
    cand = (longint'(1) << 29) / den1;
    if (dabb < cand) begin om = 2; da = dabb; end
    else da = cand;
    if (om == 0) db = 0;
    else if (om == 1) db = ONE - da;
    else begin
      longint p;
      p = (mm * da) / 16384;
      db = (p >= ONE) ? 0 : (ONE - p) / 2;
    end
    if (om == 0) den = vg;
    else if (om == 1) den = vg - 2*vc;
    else den = 2*vc;
    vla  = (vl < 0) ? -vl : vl;
    dena = (den < 0) ? -den : den;
    mag  = (den == 0) ? 0 : (vla * ONE) / dena;
    if (mag > ONE) mag = ONE;
    c = ((vl < 0) != (den < 0)) ? -mag : mag;
    if (om == 0) begin ca = c; cb = 0; end
    else if (om == 1) begin ca = c; cb = -c; end
    else begin ca = 0; cb = c; end
    a = da + ca; b = db + cb;
    if (a < 0) a = 0; if (a > ONE) a = ONE;
    if (b < 0) b = 0; if (b > ONE) b = ONE;
    if (a + b > ONE) b = ONE - a;
    oa = a; ob = b;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_busy = 0; ref_ov = 0; ref_cnt = 0;
      ref_a = 0; ref_b = 0; ref_m = 0;
    end else begin
      ref_ov = 0;
      if (ref_busy) begin
        ref_cnt++;
        if (ref_cnt == LAT) begin
          ref_busy = 0; ref_ov = 1;
          ref_a = pend_a; ref_b = pend_b; ref_m = pend_m; ref_tag = pend_tag;
        end
      end else if (in_valid) begin
        ref_busy = 1; ref_cnt = 0; pend_tag = next_tag;
        model(longint'(m_idx), longint'(da_bb), longint'($signed(vl_corr)),
              longint'(vg_abs), longint'(vc_avg), pend_a, pend_b, pend_m);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1", "in_ready", longint'(in_ready), longint'(!ref_busy));
      chk("R2", "out_valid", longint'(out_valid), longint'(ref_ov));
      chk(ref_tag, "duty_a", longint'(duty_a), ref_a);
      chk(ref_tag, "duty_b", longint'(duty_b), ref_b);
      chk(ref_tag, "op_mode", longint'(op_mode), ref_m);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL R2 watchdog expired actual %0d expected below 150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic send(input int m, input int dabb, input int vl, input int vg,
                      input int vc, input string tag, input bit noise);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    m_idx = W'(m); da_bb = W'(dabb); vl_corr = W'(vl);
    vg_abs = W'(vg); vc_avg = W'(vc);
    next_tag = tag;
    in_valid = 1'b1;
    @(negedge clk);
    if (noise) begin
      // R1: request data offered while busy must not disturb the result
      for (int k = 0; k < 20; k++) begin
        m_idx = W'(1000 + 97*k); da_bb = W'(100); vl_corr = W'(-25000);
        vg_abs = W'(3); vc_avg = W'(7);
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    repeat (LAT + 3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    m_idx = '0; da_bb = '0; vl_corr = '0; vg_abs = '0; vc_avg = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);   // R2 reset values checked by the per-cycle compare
    send(24576, 32768,      0, 20000, 10000, "R4 buck candidate",       0);
    send( 8192, 32768,      0, 20000, 10000, "R4 R6 boost candidate",   0);
    send( 4096,  8000,      0, 20000, 10000, "R5 R6 buck-boost bound",  0);
    send(24576, 21845,      0, 20000, 10000, "R5 tie keeps candidate",  0);
    send(16384, 32768,      0, 20000, 10000, "R4 m exactly one",        0);
    send(    0, 32768,      0, 20000, 10000, "R4 m zero",               0);
    send(40000, 32768,      0, 20000, 10000, "R3 m above two clamped",  0);
    send(24576, 32768,   1000, 20000, 10000, "R7 buck correction",      0);
    send( 8192, 32768,  -2000, 10000,  8000, "R8 boost correction",     0);
    send( 8192, 32768,   3000, 30000,  5000, "R8 boost positive den",   0);
    send( 4096,  8000,   3000, 20000, 12000, "R9 buck-boost correction",0);
    send(24576, 32768,  30000,   100, 10000, "R10 R11 clip high",       0);
    send( 8192, 32768,   5000, 20000, 10000, "R10 zero denominator",    0);
    send( 4096,  8000,  20000, 20000,  1000, "R11 sum clamp",           0);
    send(24576, 32768, -30000,  1000, 10000, "R11 clip low",            0);
    send( 9000, 12000,  -700,  15000,  9000, "R1 busy input ignored",   1);
    send(30000, 32768,  -500,  25000, 12000, "R7 buck negative",        0);
    repeat (5) @(negedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule